// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the bus-facing half of a serial port that sits on an APB-style peripheral bus. A host reads and writes a small window of 32-bit registers. An external byte source fills a linear receive store. Each read of the data register pops one byte from that store. Each write to the data register sends its low byte out on a valid/ready byte stream. The bus access stays open until that byte is taken.

The receive store fills from the bottom and drains from a read pointer. When the last unread byte is read, both the fill level and the read pointer return to zero. The store is not a circular buffer. A status word reports whether unread data exists and whether an incoming byte was lost because the store was full. A control word is stored as written. One of its bits enables a single-cycle interrupt pulse for every byte that is taken in. Line serialisation, baud scaling, parity, flow control and debug access are outside this block. Their control bits are kept in the control word but have no effect.

Top module: `sbuart_regif`

## Requirements
- R1: After reset the status word reads 0, the control word reads 0, `irq` is 0 and `rx_free` equals the buffer depth.
- R2: Only `paddr[7:0]` selects a register. Data is at 0x00, status at 0x04, control at 0x08, scaler at 0x0C and debug at 0x10. The upper address bits are ignored.
- R3: A read of the data register returns the oldest unread byte in bits 7:0, with zeros in bits 31:8. Successive reads return the bytes in the order they arrived.
- R4: The fill level drops back to zero only when a read leaves no unread byte. Until then, `rx_free` stays at depth minus the number of bytes written since the last full drain.
- R5: Status bit 0 (data ready) is set when a byte is taken in. It is cleared by a data read that leaves nothing unread. A data read of an empty store returns 0.
- R6: When control bit 2 is 1, each byte taken in produces `irq` high for exactly one cycle, in the cycle after the byte is offered. When control bit 2 is 0, no pulse is produced.
- R7: Writes to the status and scaler registers have no effect. The scaler, the debug register and every undecoded offset read as 0.
- R8: A write to the control register stores all 32 bits, and a read returns them unchanged.
- R9: A data-register write presents `pwdata[7:0]` on `tx_data` with `tx_valid` high. `pready` stays low until `tx_ready` is seen, and each write emits exactly one byte.
- R10: Offset 0x03 behaves exactly like offset 0x00 for both reads and writes.
- R11: A byte offered while the store is full is dropped. Status bit 4 (overrun) is then set and stays set until reset, and the stored bytes are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; low 8 bits decoded |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Access completes when high |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_free | output | $clog2(DEPTH+1) | Free space in the receive store |
| tx_valid | output | 1 | Outbound byte valid |
| tx_data | output | 8 | Outbound byte |
| tx_ready | input | 1 | Outbound byte accepted |
| irq | output | 1 | Receive interrupt pulse |

## Verification
The assertions check these invariants on every cycle:
- The fill level never exceeds the depth.
- The read pointer never passes the fill level.
- Data ready always matches the presence of unread bytes.
- Overrun is sticky.
- Every interrupt pulse follows an accepted byte.
- `pready` only drops during a data write whose byte is still waiting.
- The control word only changes on a control write.

Only the bench scenarios can show the rest:
- Arrival-order readback, including through the 0x03 alias.
- The refill-before-drain case, where `rx_free` must not recover.
- The values that writes to the status and scaler registers fail to change.
- The exact byte sequence on the outbound stream under a stalled acceptor.

// File: rtl/sbuart_pkg.sv
package sbuart_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] OFF_DATA   = 8'h00;
  localparam logic [7:0] OFF_DATA_B = 8'h03;
  localparam logic [7:0] OFF_STAT   = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h08;
  localparam logic [7:0] OFF_SCALE  = 8'h0C;
  localparam logic [7:0] OFF_DEBUG  = 8'h10;

  localparam int unsigned ST_DREADY  = 0;
  localparam int unsigned ST_OVERRUN = 4;
  localparam int unsigned CT_RX_IRQ  = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_STAT,
    SEL_CTRL,
    SEL_SCALE,
    SEL_DEBUG
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [7:0] off);
    reg_sel_e s;
    unique case (off)
      OFF_DATA, OFF_DATA_B: s = SEL_DATA;
      OFF_STAT:             s = SEL_STAT;
      OFF_CTRL:             s = SEL_CTRL;
      OFF_SCALE:            s = SEL_SCALE;
      OFF_DEBUG:            s = SEL_DEBUG;
      default:              s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sbuart_rxbuf.sv
module sbuart_rxbuf #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             pop,
  output logic [7:0]       pop_byte,
  output logic [CNT_W-1:0] fill,
  output logic             data_ready,
  output logic             accepted,
  output logic             dropped
);

  logic [7:0]       store [DEPTH];
  logic [CNT_W-1:0] fill_q, fill_d, fill_plus;
  logic [CNT_W-1:0] rd_q, rd_d, rd_inc;
  logic             ready_q, ready_d;
  logic             has_data, drained;

  always_comb begin
    accepted  = in_valid && (fill_q != CNT_W'(DEPTH));
    dropped   = in_valid && (fill_q == CNT_W'(DEPTH));
    has_data  = rd_q < fill_q;
    fill_plus = fill_q + CNT_W'(accepted);
    rd_inc    = rd_q + CNT_W'(1);
    drained   = has_data && (rd_inc >= fill_plus);

    fill_d  = fill_plus;
    rd_d    = rd_q;
    ready_d = ready_q;
    if (pop && has_data) begin
      if (drained) begin
        fill_d = '0;
        rd_d   = '0;
      end else begin
        rd_d = rd_inc;
      end
    end
    if (accepted) begin
      ready_d = 1'b1;
    end else if (pop && (!has_data || drained)) begin
      ready_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      rd_q    <= '0;
      ready_q <= 1'b0;
    end else begin
      fill_q  <= fill_d;
      rd_q    <= rd_d;
      ready_q <= ready_d;
    end
  end

  // Storage array carries no reset; only written slots are ever read.
  always_ff @(posedge clk) begin
    if (accepted) begin
      store[fill_q[PTR_W-1:0]] <= in_byte;
    end
  end

  assign pop_byte   = has_data ? store[rd_q[PTR_W-1:0]] : 8'h00;
  assign fill       = fill_q;
  assign data_ready = ready_q;

  // R11
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(DEPTH))
    else $error("fill level above depth");

  // R4
  rd_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q < fill_q) || (rd_q == '0 && fill_q == '0))
    else $error("read pointer outside filled region");

  // R5
  ready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q == (rd_q < fill_q))
    else $error("data ready disagrees with unread count");

  // R11
  drop_keeps_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dropped && !pop) |=> (fill_q == CNT_W'(DEPTH)))
    else $error("dropped byte changed fill level");

endmodule

// File: rtl/sbuart_txport.sv
module sbuart_txport (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [7:0] wbyte,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       stall
);

  assign tx_valid = req;
  assign tx_data  = wbyte;
  assign stall    = req && !tx_ready;

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)))
    else $error("outbound byte withdrawn before acceptance");

endmodule

// File: rtl/sbuart_csr.sv
module sbuart_csr
  import sbuart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rx_accepted,
  input  logic              rx_dropped,
  input  logic              data_ready,
  output logic [WORD_W-1:0] ctrl_word,
  output logic [WORD_W-1:0] status_word,
  output logic              irq
);

  logic [WORD_W-1:0] ctrl_q, ctrl_d;
  logic              ovr_q, ovr_d;
  logic              irq_q, irq_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d = wdata;
    end
    ovr_d = ovr_q | rx_dropped;
    irq_d = rx_accepted & ctrl_q[CT_RX_IRQ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ovr_q  <= ovr_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    status_word              = '0;
    status_word[ST_DREADY]   = data_ready;
    status_word[ST_OVERRUN]  = ovr_q;
  end

  assign ctrl_word = ctrl_q;
  assign irq       = irq_q;

  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q)
    else $error("overrun flag cleared without reset");

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(rx_accepted))
    else $error("interrupt without accepted byte");

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q))
    else $error("control word changed without write");

endmodule

// File: rtl/sbuart_regif.sv
module sbuart_regif
  import sbuart_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic [CNT_W-1:0]  rx_free,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              irq
);

  reg_sel_e          sel;
  logic              access, rd_done, wr_done, tx_req, tx_stall;
  logic              pop;
  logic [7:0]        pop_byte;
  logic [CNT_W-1:0]  fill;
  logic              data_ready, rx_acc, rx_drop;
  logic [WORD_W-1:0] ctrl_word, status_word;

  always_comb begin
    sel     = decode_offset(paddr[7:0]);
    access  = psel && penable;
    tx_req  = access && pwrite && (sel == SEL_DATA);
    pready  = !tx_stall;
    rd_done = access && !pwrite && pready;
    wr_done = access && pwrite && pready;
    pop     = rd_done && (sel == SEL_DATA);
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: prdata = {24'h0, pop_byte};
      SEL_STAT: prdata = status_word;
      SEL_CTRL: prdata = ctrl_word;
      default:  prdata = '0;
    endcase
  end

  sbuart_rxbuf #(.DEPTH(DEPTH)) rxbuf_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (rx_valid),
    .in_byte    (rx_data),
    .pop        (pop),
    .pop_byte   (pop_byte),
    .fill       (fill),
    .data_ready (data_ready),
    .accepted   (rx_acc),
    .dropped    (rx_drop)
  );

  sbuart_txport txport_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (tx_req),
    .wbyte    (pwdata[7:0]),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .stall    (tx_stall)
  );

  sbuart_csr csr_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (wr_done && (sel == SEL_CTRL)),
    .wdata       (pwdata),
    .rx_accepted (rx_acc),
    .rx_dropped  (rx_drop),
    .data_ready  (data_ready),
    .ctrl_word   (ctrl_word),
    .status_word (status_word),
    .irq         (irq)
  );

  assign rx_free = CNT_W'(DEPTH) - fill;

  // R9
  wait_only_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pready |-> (psel && penable && pwrite && tx_valid && !tx_ready))
    else $error("bus stalled outside a pending data write");

  // R3
  read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && sel == SEL_DATA) |-> (prdata[31:8] == 24'h0))
    else $error("data read carries upper bits");

endmodule

// File: tb/sbuart_regif_tb_top.sv
module sbuart_regif_tb_top;

  localparam int unsigned DEPTH = 8;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0]      paddr = '0;
  logic [31:0]      pwdata = '0;
  logic [31:0]      prdata;
  logic             pready;
  logic             rx_valid = 1'b0;
  logic [7:0]       rx_data = '0;
  logic [CNT_W-1:0] rx_free;
  logic             tx_valid;
  logic [7:0]       tx_data;
  logic             tx_ready = 1'b1;
  logic             irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] rx_exp[$];
  logic [7:0] tx_exp[$];
  int         mfill = 0;

  always #5 clk = ~clk;

  sbuart_regif #(.DEPTH(DEPTH), .ADDR_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_free(rx_free),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] wd,
                      output logic [31:0] rd);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
    @(posedge clk); #1;
    penable = 1'b1;
    @(negedge clk);
    while (!pready) @(negedge clk);
    rd = prdata;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] wd);
    logic [31:0] dummy;
    xfer(1'b1, a, wd, dummy);
  endtask

  task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string req);
    logic [31:0] got;
    xfer(1'b0, a, 32'h0, got);
    check(got === exp, req, got, exp);
  endtask

  // Driver: offers one byte, updates the reference model, checks the pulse.
  task automatic push_rx(input logic [7:0] b, input bit irq_en);
    bit take;
    take = (mfill < DEPTH);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
    if (take) begin
      rx_exp.push_back(b);
      mfill++;
    end
    @(negedge clk);
    check(irq === (irq_en && take), "R6 pulse", {31'h0, irq}, {31'h0, irq_en && take});
    @(negedge clk);
    check(irq === 1'b0, "R6 single cycle", {31'h0, irq}, 32'h0);
  endtask

  // Pops one expected byte and compares the data read against it.
  task automatic pop_check(input logic [11:0] a, input string req);
    logic [31:0] got;
    logic [31:0] exp;
    exp = 32'h0;
    if (rx_exp.size() > 0) exp = {24'h0, rx_exp.pop_front()};
    if (rx_exp.size() == 0) mfill = 0;
    xfer(1'b0, a, 32'h0, got);
    check(got === exp, req, got, exp);
  endtask

  task automatic free_check(input string req);
    @(negedge clk);
    check(rx_free === CNT_W'(DEPTH - mfill), req, {28'h0, rx_free}, DEPTH - mfill);
  endtask

  task automatic send_tx(input logic [11:0] a, input logic [31:0] wd, input int stall);
    tx_exp.push_back(wd[7:0]);
    if (stall == 0) begin
      wr_reg(a, wd);
    end else begin
      tx_ready = 1'b0;
      fork
        wr_reg(a, wd);
        begin
          repeat (stall) @(negedge clk);
          check(pready === 1'b0, "R9 stall", {31'h0, pready}, 32'h0);
          #2 tx_ready = 1'b1;
        end
      join
    end
  endtask

  // Monitor: compares each outbound byte against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (tx_exp.size() == 0) begin
        check(1'b0, "R9 unexpected byte", {24'h0, tx_data}, 32'h0);
      end else begin
        logic [7:0] e;
        e = tx_exp.pop_front();
        check(tx_data === e, "R9 byte", {24'h0, tx_data}, {24'h0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(irq === 1'b0, "R1 irq", {31'h0, irq}, 32'h0);
    check(rx_free === CNT_W'(DEPTH), "R1 free", {28'h0, rx_free}, DEPTH);
    rd_check(12'h004, 32'h0, "R1 status");
    rd_check(12'h008, 32'h0, "R1 control");

    // R8 full word stored
    wr_reg(12'h008, 32'hA5A5_1234);
    rd_check(12'h008, 32'hA5A5_1234, "R8 readback");
    // R2 upper address bits ignored
    rd_check(12'hF08, 32'hA5A5_1234, "R2 alias read");
    wr_reg(12'h308, 32'h0000_0004);
    rd_check(12'h008, 32'h0000_0004, "R2 alias write");

    // R7 ignored writes and zero reads
    wr_reg(12'h004, 32'hFFFF_FFFF);
    rd_check(12'h004, 32'h0, "R7 status write");
    wr_reg(12'h00C, 32'h0000_00FF);
    rd_check(12'h00C, 32'h0, "R7 scaler");
    rd_check(12'h010, 32'h0, "R7 debug");
    rd_check(12'h014, 32'h0, "R7 unknown");
    rd_check(12'h040, 32'h0, "R7 unknown high");

    // R5 R6 R3 R10 arrival, order and alias
    push_rx(8'h11, 1'b1);
    push_rx(8'h22, 1'b1);
    rd_check(12'h004, 32'h1, "R5 ready set");
    pop_check(12'h000, "R3 first byte");
    pop_check(12'h003, "R10 alias read");
    rd_check(12'h004, 32'h0, "R5 ready clear");
    free_check("R4 drained");
    pop_check(12'h000, "R5 empty read");

    // R6 disabled
    wr_reg(12'h008, 32'h0);
    push_rx(8'h33, 1'b0);
    pop_check(12'h000, "R3 byte without irq");

    // R9 R10 outbound bytes
    send_tx(12'h000, 32'h1234_56AB, 0);
    send_tx(12'h003, 32'h0000_00CD, 0);
    send_tx(12'h000, 32'hFFFF_FF5E, 3);

    // R11 overflow
    for (int i = 0; i < DEPTH; i++) push_rx(8'(i * 7 + 1), 1'b0);
    free_check("R11 full");
    push_rx(8'hEE, 1'b0);
    rd_check(12'h004, 32'h11, "R11 overrun set");
    for (int i = 0; i < DEPTH; i++) pop_check(12'h000, "R11 contents kept");
    free_check("R4 drained after full");
    wr_reg(12'h004, 32'h0);
    rd_check(12'h004, 32'h10, "R11 overrun sticky");

    // R4 refill before drain keeps fill level
    push_rx(8'hA1, 1'b0);
    push_rx(8'hA2, 1'b0);
    push_rx(8'hA3, 1'b0);
    pop_check(12'h000, "R3 partial");
    push_rx(8'hA4, 1'b0);
    free_check("R4 no early reset");
    pop_check(12'h000, "R3 after refill");
    pop_check(12'h000, "R3 after refill");
    pop_check(12'h000, "R3 after refill");
    free_check("R4 final drain");

    repeat (2) @(negedge clk);
    check(tx_exp.size() == 0, "R9 all bytes sent", tx_exp.size(), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule